// File: doc/BRIEF.md
# In-Order Load/Store Queue Controller

This block holds memory operations in program order between dispatch and the memory unit. Dispatch writes a new entry at the tail. Each entry records whether it is a load or a store, a register tag, a reorder-buffer index and a control-flow label. The address is computed elsewhere. It arrives later through a write port that names the slot, so slots can receive their addresses in any order. Only the oldest entry may start an access. All accesses go to one non-pipelined memory unit that is busy for three cycles per access. An entry is removed from the queue in the cycle its access begins.

A load at the head starts once its address is present and the memory unit is free. It does not wait for the reorder buffer. While the load is in the memory unit, the block announces the destination tag one cycle before the data, so that dependent operations can prepare. A store also needs its reorder-buffer entry to be the oldest in the machine and its data register to be valid. The block reads that register's state through a lookup that it drives with the head store's tag. When the store starts, the block tells the reorder buffer that the store may retire. There is no address comparison between entries: no load bypasses a store and no data is forwarded. A flush mask of control-flow labels removes the matching entries from the young end of the queue and moves the tail back. It also silences a load already in the memory unit if that load's label is flushed.

Top module: `lsq_ctrl`

## Requirements
- R1: After reset the queue is empty. `alloc_idx` is 0, `alloc_full` is 0, and `mem_start`, `tag_bc_valid`, `data_bc_valid` and `st_started` are all 0.
- R2: `alloc_idx` names the slot the next allocation uses. It advances by one per accepted allocation and wraps from DEPTH-1 (19) to 0. `alloc_full` is 1 while DEPTH entries are held. An allocation request while full is ignored and leaves `alloc_idx` unchanged.
- R3: An address write stores `addr_wr_data` into slot `addr_wr_idx` and marks that slot's address valid. Only the head entry may start an access. A younger entry that has its address waits while the head entry lacks one.
- R4: A load at the head starts when its address is valid and the memory unit is free, whatever the reorder-buffer inputs say. Its start shows one cycle later as a one-cycle `mem_start` pulse with `mem_we`=0 and `mem_addr` equal to the entry's address.
- R5: Accesses do not overlap. Two `mem_start` pulses are at least 3 cycles apart, and two ready entries start exactly 3 cycles apart.
- R6: For a load, `tag_bc_valid` is 1 with the load's tag in the second access cycle. `data_bc_valid` is 1 with the same tag in the third access cycle, and `data_bc_data` is then the value on `mem_rdata`.
- R7: A store at the head starts only if its address is valid, `rob_head_valid` is 1, `rob_head_idx` equals its reorder-buffer index, `lookup_valid` is 1 and the memory unit is free. While the store is at the head, `lookup_tag` carries its data register tag.
- R8: When a store starts, `mem_start`, `mem_we`=1 and `st_started` are all 1 in the same cycle. `mem_wdata` equals the `lookup_data` sampled at the start, and `st_rob_idx` is the store's reorder-buffer index. `st_started` lasts one cycle.
- R9: An entry leaves the queue in the cycle its access begins. A full queue shows `alloc_full`=0 in the same cycle as the head's `mem_start`.
- R10: Each entry whose label has its bit set in `flush_mask` is discarded, and `alloc_idx` moves back to the slot of the oldest discarded entry.
- R11: A load in the memory unit whose label is flushed during its first access cycle produces neither a tag broadcast nor a data broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a new entry at the tail |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_tag | input | TAGW | Load destination tag, or store data register tag |
| alloc_rob | input | ROBW | Reorder-buffer index of the operation |
| alloc_cfid | input | CFW | Control-flow label of the operation |
| alloc_idx | output | IW | Slot the next allocation uses |
| alloc_full | output | 1 | Queue holds DEPTH entries |
| addr_wr_valid | input | 1 | Address write strobe |
| addr_wr_idx | input | IW | Slot receiving the address |
| addr_wr_data | input | AW | Computed address |
| lookup_tag | output | TAGW | Data register tag of the head entry |
| lookup_valid | input | 1 | The looked-up register is valid |
| lookup_data | input | DW | The looked-up register value |
| rob_head_valid | input | 1 | Reorder buffer is non-empty |
| rob_head_idx | input | ROBW | Index of the oldest reorder-buffer entry |
| flush_mask | input | CFN | One bit per control-flow label to discard |
| mem_rdata | input | DW | Read data, valid in the third access cycle |
| mem_start | output | 1 | First cycle of an access |
| mem_we | output | 1 | Current access is a write |
| mem_addr | output | AW | Access address, held for the access |
| mem_wdata | output | DW | Write data, held for the access |
| st_started | output | 1 | A store began its access |
| st_rob_idx | output | ROBW | Reorder-buffer index of that store |
| tag_bc_valid | output | 1 | Early tag broadcast of a load |
| tag_bc_tag | output | TAGW | Broadcast tag |
| data_bc_valid | output | 1 | Load result broadcast |
| data_bc_tag | output | TAGW | Tag of the result |
| data_bc_data | output | DW | Result value |

## Verification
The bench writes the address of a younger load before the head's address. A queue that issued out of order would start the younger load too early and with the wrong address. A store is held back first by a reorder-buffer mismatch and then by an invalid data register. A design that skipped either condition would write memory too soon or retire the store too soon. Two ready loads are checked for exactly three cycles between starts, which catches both an overlapping and a needlessly slow memory unit. The bench fills the queue, frees one slot by starting the head, and then flushes two labels. A design that freed entries at completion, or that moved the tail back to the wrong slot, shows a wrong `alloc_full` or `alloc_idx`. A flushed in-flight load must stay silent, or it would wake dependents on a discarded path.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_e;
endpackage

// File: rtl/lsq_flush_scan.sv
// Finds how many entries, counted from the head, survive a flush.
module lsq_flush_scan #(
  parameter int DEPTH = 20,
  parameter int CFN   = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int CFW  = $clog2(CFN)
) (
  input  logic [IW-1:0]  head,
  input  logic [CW-1:0]  count,
  input  logic [CFN-1:0] flush_mask,
  input  logic [CFW-1:0] ent_cf [DEPTH],
  output logic           any_hit,
  output logic           head_hit,
  output logic [CW-1:0]  keep_cnt
);
  logic [DEPTH-1:0] slot_hit;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
      assign slot_hit[g] = flush_mask[ent_cf[g]];
    end
  endgenerate

  always_comb begin
    any_hit  = 1'b0;
    keep_cnt = count;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW:0] s;
      s = {1'b0, head} + (IW+1)'(k);
      if (s >= (IW+1)'(DEPTH)) s = s - (IW+1)'(DEPTH);
      if (!any_hit && (CW'(k) < count) && slot_hit[s[IW-1:0]]) begin
        any_hit  = 1'b1;
        keep_cnt = CW'(k);
      end
    end
    head_hit = any_hit && (keep_cnt == '0);
  end
endmodule

// File: rtl/lsq_head_sel.sv
// Decides whether the head entry may begin its memory access this cycle.
module lsq_head_sel #(
  parameter int ROBW = 5
) (
  input  logic            not_empty,
  input  logic            head_hit,
  input  logic            mem_free,
  input  lsq_pkg::acc_e   head_kind,
  input  logic            head_aok,
  input  logic [ROBW-1:0] head_rob,
  input  logic            rob_head_valid,
  input  logic [ROBW-1:0] rob_head_idx,
  input  logic            lookup_valid,
  output logic            start,
  output logic            start_we
);
  logic base_ok, store_ok;

  always_comb begin
    base_ok  = not_empty && !head_hit && mem_free && head_aok;
    store_ok = rob_head_valid && (rob_head_idx == head_rob) && lookup_valid;
    start_we = (head_kind == lsq_pkg::ACC_STORE);
    start    = base_ok && (!start_we || store_ok);
  end
endmodule

// File: rtl/lsq_mem_seq.sv
// Sequencer for the single non-pipelined memory unit and the load broadcasts.
module lsq_mem_seq #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TAGW = 6,
  parameter int ROBW = 5,
  parameter int CFN  = 8,
  parameter int LAT  = 3,
  localparam int CFW = $clog2(CFN),
  localparam int LW  = $clog2(LAT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_we,
  input  logic [AW-1:0]   start_addr,
  input  logic [DW-1:0]   start_wdata,
  input  logic [TAGW-1:0] start_tag,
  input  logic [ROBW-1:0] start_rob,
  input  logic [CFW-1:0]  start_cf,
  input  logic [CFN-1:0]  flush_mask,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_free,
  output logic            mem_start,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            st_started,
  output logic [ROBW-1:0] st_rob_idx,
  output logic            tag_bc_valid,
  output logic [TAGW-1:0] tag_bc_tag,
  output logic            data_bc_valid,
  output logic [TAGW-1:0] data_bc_tag,
  output logic [DW-1:0]   data_bc_data
);
  logic [LW-1:0]   left_q;
  logic            we_q, kill_q;
  logic [TAGW-1:0] tag_q;
  logic [CFW-1:0]  cf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q     <= '0;
      we_q       <= 1'b0;
      kill_q     <= 1'b0;
      mem_start  <= 1'b0;
      st_started <= 1'b0;
    end else begin
      mem_start  <= start;
      st_started <= start && start_we;
      if (start) begin
        left_q <= LW'(LAT);
        we_q   <= start_we;
        kill_q <= 1'b0;
      end else begin
        if (left_q != '0) left_q <= left_q - 1'b1;
        if ((left_q != '0) && flush_mask[cf_q]) kill_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      mem_addr   <= start_addr;
      mem_wdata  <= start_wdata;
      tag_q      <= start_tag;
      cf_q       <= start_cf;
      st_rob_idx <= start_rob;
    end
  end

  always_comb begin
    mem_free      = (left_q <= LW'(1));
    mem_we        = we_q && (left_q != '0);
    tag_bc_valid  = (left_q == LW'(LAT-1)) && !we_q && !kill_q;
    tag_bc_tag    = tag_q;
    data_bc_valid = (left_q == LW'(1)) && !we_q && !kill_q;
    data_bc_tag   = tag_q;
    data_bc_data  = mem_rdata;
  end
endmodule

// File: rtl/lsq_ctrl.sv
// In-order load/store queue: storage, pointers, allocation, address writes, flush.
module lsq_ctrl #(
  parameter int DEPTH = 20,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TAGW  = 6,
  parameter int ROBW  = 5,
  parameter int CFN   = 8,
  parameter int LAT   = 3,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int CFW  = $clog2(CFN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_valid,
  input  logic            alloc_is_store,
  input  logic [TAGW-1:0] alloc_tag,
  input  logic [ROBW-1:0] alloc_rob,
  input  logic [CFW-1:0]  alloc_cfid,
  output logic [IW-1:0]   alloc_idx,
  output logic            alloc_full,
  input  logic            addr_wr_valid,
  input  logic [IW-1:0]   addr_wr_idx,
  input  logic [AW-1:0]   addr_wr_data,
  output logic [TAGW-1:0] lookup_tag,
  input  logic            lookup_valid,
  input  logic [DW-1:0]   lookup_data,
  input  logic            rob_head_valid,
  input  logic [ROBW-1:0] rob_head_idx,
  input  logic [CFN-1:0]  flush_mask,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_start,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            st_started,
  output logic [ROBW-1:0] st_rob_idx,
  output logic            tag_bc_valid,
  output logic [TAGW-1:0] tag_bc_tag,
  output logic            data_bc_valid,
  output logic [TAGW-1:0] data_bc_tag,
  output logic [DW-1:0]   data_bc_data
);
  import lsq_pkg::*;

  acc_e            ent_kind [DEPTH];
  logic [TAGW-1:0] ent_tag  [DEPTH];
  logic [ROBW-1:0] ent_rob  [DEPTH];
  logic [CFW-1:0]  ent_cf   [DEPTH];
  logic [AW-1:0]   ent_addr [DEPTH];
  logic [DEPTH-1:0] ent_aok;

  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  logic          any_hit, head_hit, mem_free, start, start_we, alloc_do;
  logic [CW-1:0] keep_cnt;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] base,
                                             input logic [CW-1:0] off);
    logic [IW+1:0] s;
    s = (IW+2)'(base) + (IW+2)'(off);
    if (s >= (IW+2)'(DEPTH)) s = s - (IW+2)'(DEPTH);
    return s[IW-1:0];
  endfunction

  assign alloc_full = (count_q == CW'(DEPTH));
  assign alloc_idx  = tail_q;
  assign alloc_do   = alloc_valid && !alloc_full && !any_hit;
  assign lookup_tag = ent_tag[head_q];

  lsq_flush_scan #(.DEPTH(DEPTH), .CFN(CFN)) u_scan (
    .head(head_q), .count(count_q), .flush_mask(flush_mask), .ent_cf(ent_cf),
    .any_hit(any_hit), .head_hit(head_hit), .keep_cnt(keep_cnt)
  );

  lsq_head_sel #(.ROBW(ROBW)) u_sel (
    .not_empty(count_q != '0), .head_hit(head_hit), .mem_free(mem_free),
    .head_kind(ent_kind[head_q]), .head_aok(ent_aok[head_q]),
    .head_rob(ent_rob[head_q]), .rob_head_valid(rob_head_valid),
    .rob_head_idx(rob_head_idx), .lookup_valid(lookup_valid),
    .start(start), .start_we(start_we)
  );

  lsq_mem_seq #(.AW(AW), .DW(DW), .TAGW(TAGW), .ROBW(ROBW), .CFN(CFN), .LAT(LAT)) u_mem (
    .clk(clk), .rst(rst), .start(start), .start_we(start_we),
    .start_addr(ent_addr[head_q]), .start_wdata(lookup_data),
    .start_tag(ent_tag[head_q]), .start_rob(ent_rob[head_q]),
    .start_cf(ent_cf[head_q]), .flush_mask(flush_mask), .mem_rdata(mem_rdata),
    .mem_free(mem_free), .mem_start(mem_start), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st_started(st_started),
    .st_rob_idx(st_rob_idx), .tag_bc_valid(tag_bc_valid), .tag_bc_tag(tag_bc_tag),
    .data_bc_valid(data_bc_valid), .data_bc_tag(data_bc_tag),
    .data_bc_data(data_bc_data)
  );

  // Pointer and occupancy update
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (start) head_q <= wrap_add(head_q, CW'(1));
      if (any_hit) begin
        tail_q  <= wrap_add(head_q, keep_cnt);
        count_q <= keep_cnt - CW'(start);
      end else begin
        if (alloc_do) tail_q <= wrap_add(tail_q, CW'(1));
        count_q <= count_q + CW'(alloc_do) - CW'(start);
      end
    end
  end

  // Address-valid flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_aok <= '0;
    end else begin
      if (addr_wr_valid) ent_aok[addr_wr_idx] <= 1'b1;
      if (alloc_do) ent_aok[tail_q] <= 1'b0;
    end
  end

  // Entry payload storage, no reset, single write per array
  always_ff @(posedge clk) begin
    if (alloc_do) begin
      ent_kind[tail_q] <= alloc_is_store ? ACC_STORE : ACC_LOAD;
      ent_tag[tail_q]  <= alloc_tag;
      ent_rob[tail_q]  <= alloc_rob;
      ent_cf[tail_q]   <= alloc_cfid;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_wr_valid) ent_addr[addr_wr_idx] <= addr_wr_data;
  end
endmodule

// File: rtl/lsq_ctrl_chk.sv
module lsq_ctrl_chk #(
  parameter int IW   = 5,
  parameter int TAGW = 6,
  parameter int CFN  = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            alloc_valid,
  input logic            alloc_full,
  input logic [IW-1:0]   alloc_idx,
  input logic [CFN-1:0]  flush_mask,
  input logic            mem_start,
  input logic            mem_we,
  input logic            st_started,
  input logic            tag_bc_valid,
  input logic [TAGW-1:0] tag_bc_tag,
  input logic            data_bc_valid,
  input logic [TAGW-1:0] data_bc_tag
);
  assert_gap1_R5: assert property (@(posedge clk) disable iff (rst)
    mem_start |=> !mem_start);
  assert_gap2_R5: assert property (@(posedge clk) disable iff (rst)
    mem_start |=> ##1 !mem_start);
  assert_store_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    st_started |-> (mem_start && mem_we));
  assert_data_follows_tag_R6: assert property (@(posedge clk) disable iff (rst)
    data_bc_valid |-> ($past(tag_bc_valid) && (data_bc_tag == $past(tag_bc_tag))));
  assert_bcast_only_load_R6: assert property (@(posedge clk) disable iff (rst)
    (tag_bc_valid || data_bc_valid) |-> !mem_we);
  assert_full_ignores_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_full && alloc_valid && (flush_mask == '0)) |=> (alloc_idx == $past(alloc_idx)));
endmodule

bind lsq_ctrl lsq_ctrl_chk #(.IW(IW), .TAGW(TAGW), .CFN(CFN)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_full(alloc_full),
  .alloc_idx(alloc_idx), .flush_mask(flush_mask), .mem_start(mem_start),
  .mem_we(mem_we), .st_started(st_started), .tag_bc_valid(tag_bc_valid),
  .tag_bc_tag(tag_bc_tag), .data_bc_valid(data_bc_valid), .data_bc_tag(data_bc_tag)
);

// File: tb/sim_lsq_ctrl.sv
module sim_lsq_ctrl;
  localparam int DEPTH = 20, IW = 5, TAGW = 6, ROBW = 5, CFN = 8, CFW = 3;

  logic clk = 0, rst = 1;
  logic alloc_valid = 0, alloc_is_store = 0;
  logic [TAGW-1:0] alloc_tag = 0;
  logic [ROBW-1:0] alloc_rob = 0;
  logic [CFW-1:0] alloc_cfid = 0;
  logic [IW-1:0] alloc_idx;
  logic alloc_full;
  logic addr_wr_valid = 0;
  logic [IW-1:0] addr_wr_idx = 0;
  logic [31:0] addr_wr_data = 0;
  logic [TAGW-1:0] lookup_tag;
  logic lookup_valid = 0;
  logic [31:0] lookup_data = 0;
  logic rob_head_valid = 0;
  logic [ROBW-1:0] rob_head_idx = 0;
  logic [CFN-1:0] flush_mask = 0;
  logic [31:0] mem_rdata;
  logic mem_start, mem_we, st_started, tag_bc_valid, data_bc_valid;
  logic [31:0] mem_addr, mem_wdata, data_bc_data;
  logic [ROBW-1:0] st_rob_idx;
  logic [TAGW-1:0] tag_bc_tag, data_bc_tag;

  int n_chk = 0, n_fail = 0, exp_tail = 0, cyc = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0F0F_0F0F;
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  lsq_ctrl u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic st, input int tag, input int rob, input int cf);
    alloc_valid = 1; alloc_is_store = st; alloc_tag = TAGW'(tag);
    alloc_rob = ROBW'(rob); alloc_cfid = CFW'(cf);
    tick();
    alloc_valid = 0;
    exp_tail = (exp_tail + 1) % DEPTH;
  endtask

  task automatic do_addr(input int idx, input logic [31:0] a);
    addr_wr_valid = 1; addr_wr_idx = IW'(idx); addr_wr_data = a;
    tick();
    addr_wr_valid = 0;
  endtask

  // address, tag, label
  localparam logic [40:0] VEC [4] = '{
    {32'h0000_1000, 6'd5,  3'd0},
    {32'hDEAD_BEE0, 6'd17, 3'd1},
    {32'h1234_5678, 6'd33, 3'd4},
    {32'hFFFF_FFFC, 6'd63, 3'd7}
  };

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int base, slot;
    logic [31:0] a;
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    chk("R1 idx", 64'(alloc_idx), 0);
    chk("R1 full", 64'(alloc_full), 0);
    chk("R1 start", 64'(mem_start), 0);
    chk("R1 bcast", 64'({tag_bc_valid, data_bc_valid, st_started}), 0);

    // Table walk: loads, no reorder-buffer match offered (R4, R6)
    for (int i = 0; i < 4; i++) begin
      a = VEC[i][40:9];
      chk("R2 idx", 64'(alloc_idx), 64'(exp_tail));
      slot = exp_tail;
      do_alloc(0, int'(VEC[i][8:3]), i, int'(VEC[i][2:0]));
      do_addr(slot, a);
      chk("R4 no early start", 64'(mem_start), 0);
      tick();
      chk("R4 start", 64'({mem_start, mem_we}), 64'(2'b10));
      chk("R4 addr", 64'(mem_addr), 64'(a));
      tick();
      chk("R6 tag", 64'({tag_bc_valid, data_bc_valid, tag_bc_tag}), 64'({2'b10, VEC[i][8:3]}));
      tick();
      chk("R6 data", 64'({tag_bc_valid, data_bc_valid, data_bc_tag}), 64'({2'b01, VEC[i][8:3]}));
      chk("R6 value", 64'(data_bc_data), 64'(mem_model(a)));
      tick();
    end

    // R7/R8 store gating
    slot = exp_tail;
    do_alloc(1, 9, 5, 0);
    do_addr(slot, 32'h0000_2000);
    rob_head_valid = 1; rob_head_idx = 3; lookup_valid = 1; lookup_data = 32'hCAFE_0001;
    tick(); tick();
    chk("R7 rob mismatch", 64'(mem_start), 0);
    rob_head_idx = 5; lookup_valid = 0;
    tick(); tick();
    chk("R7 data invalid", 64'(mem_start), 0);
    chk("R7 lookup tag", 64'(lookup_tag), 9);
    lookup_valid = 1;
    tick();
    chk("R8 start", 64'({mem_start, mem_we, st_started}), 64'(3'b111));
    chk("R8 rob", 64'(st_rob_idx), 5);
    chk("R8 wdata", 64'(mem_wdata), 64'h0000_0000_CAFE_0001);
    rob_head_valid = 0; lookup_valid = 0; lookup_data = 0;
    tick();
    chk("R8 pulse", 64'({mem_start, st_started}), 0);
    chk("R8 held", 64'(mem_wdata), 64'h0000_0000_CAFE_0001);
    tick(); tick();

    // R3 head only, R5 spacing
    base = exp_tail;
    do_alloc(0, 1, 0, 0);
    do_alloc(0, 2, 1, 0);
    do_addr((base + 1) % DEPTH, 32'h0000_0B00);
    tick();
    chk("R3 younger waits", 64'(mem_start), 0);
    do_addr(base, 32'h0000_0A00);
    tick();
    chk("R3 head first", 64'({mem_start, mem_addr}), 64'({1'b1, 32'h0000_0A00}));
    tick();
    chk("R5 busy1", 64'(mem_start), 0);
    tick();
    chk("R5 busy2", 64'(mem_start), 0);
    tick();
    chk("R5 back-to-back", 64'({mem_start, mem_addr}), 64'({1'b1, 32'h0000_0B00}));
    repeat (4) tick();

    // R2 fill, R9 leave at start, R10 flush roll-back
    base = exp_tail;
    for (int k = 0; k < DEPTH; k++)
      do_alloc(0, k, k, (k == 0) ? 0 : ((k < 12) ? 1 : 2));
    chk("R2 full", 64'(alloc_full), 1);
    chk("R2 wrap", 64'(alloc_idx), 64'(base));
    alloc_valid = 1; alloc_cfid = 0;
    tick();
    alloc_valid = 0;
    chk("R2 full ignored", 64'({alloc_full, alloc_idx}), 64'({1'b1, 5'(base)}));
    do_addr(base, 32'h0000_4000);
    tick();
    chk("R9 start", 64'(mem_start), 1);
    chk("R9 slot freed", 64'(alloc_full), 0);
    flush_mask = 8'b0000_0100;
    tick();
    chk("R10 rollback", 64'(alloc_idx), 64'((base + 12) % DEPTH));
    flush_mask = 8'b0000_0010;
    tick();
    flush_mask = 0;
    chk("R10 rollback empty", 64'(alloc_idx), 64'((base + 1) % DEPTH));
    exp_tail = (base + 1) % DEPTH;
    repeat (3) tick();

    // R11 flushed in-flight load is silent
    slot = exp_tail;
    do_alloc(0, 44, 0, 3);
    do_addr(slot, 32'h0000_5000);
    tick();
    chk("R11 start", 64'(mem_start), 1);
    flush_mask = 8'b0000_1000;
    tick();
    flush_mask = 0;
    chk("R11 no tag", 64'(tag_bc_valid), 0);
    tick();
    chk("R11 no data", 64'(data_bc_valid), 0);
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule